// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block drives one shared successive-approximation converter of `DW` bits that serves up to `CH` input channels, all captured at the same instant. A host pulses an active-low write strobe while chip select is low. The falling edge makes the block raise a one-cycle hold request, so every channel's track/hold captures at once. The rising edge, when the configuration written with it allows, starts a conversion run.

During a run the block takes the selected channels one after another, lowest first. Each channel gets a fixed slot of `SLOT` clocks. Inside the slot, one cycle starts the channel and one cycle lets the input settle. Then come `DW` bit trials, most significant bit first, each judged by an external comparator bit. After the trials, the result is written into a per-channel result memory, and idle cycles pad the slot to its full length. An active-low busy flag is held low for the whole run. The result memory can be read at any time through an asynchronous read port.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy_n is 1, samp is 0 and every result memory entry reads 0.
- R2: A falling edge on wr_n that is seen while cs_n is 0 and busy_n is 1 produces exactly one samp pulse, in the cycle after the edge is registered. This happens whatever the inhibit, power-down and channel settings are.
- R3: A rising edge on wr_n starts a run when cs_n is 0, busy_n is 1, cfg_inhibit is 0, cfg_pdown is 0 and the channel list is not empty. busy_n goes low at the clock edge that registers the rising edge.
- R4: busy_n stays low for exactly 18·N clock cycles, where N is the number of channels in the list. It then returns to 1.
- R5: Channels are converted in ascending index order, and conv_chan shows the channel being worked on.
- R6: Each result is the SAR code, formed MSB first. A trial bit is kept when cmp_in is 1, which means the input is at or above trial_code. The result is stored at entry conv_chan.
- R7: With cfg_single = 1, only channel cfg_addr is converted (N = 1). All other memory entries keep their values.
- R8: With cfg_inhibit = 1 no run starts and the memory is unchanged.
- R9: With cfg_pdown = 1 no run starts and the memory is unchanged.
- R10: With cs_n = 1, strobe edges produce neither samp nor a run.
- R11: Strobe edges that arrive while busy_n is 0 are ignored. They produce no samp, do not restart or lengthen the run, and a rising edge registered in the final cycle of a run does not start a new one.
- R12: With cfg_single = 0 and chan_mask = 0 (empty list) no run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select qualifying the strobe |
| wr_n | input | 1 | Active-low write strobe (falling: sample, rising: start) |
| cfg_inhibit | input | 1 | 1 blocks the start of a run |
| cfg_pdown | input | 1 | 1 means powered down; no run starts |
| cfg_single | input | 1 | 1 converts only channel cfg_addr |
| cfg_addr | input | $clog2(CH) | Channel for single mode |
| chan_mask | input | CH | Channel list for multi-channel mode (bit i = channel i) |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial_code |
| samp | output | 1 | One-cycle hold request to all track/holds |
| busy_n | output | 1 | Low for the whole run |
| conv_chan | output | $clog2(CH) | Channel currently converted |
| trial_code | output | DW | Level offered to the comparator |
| rd_addr | input | $clog2(CH) | Result memory read address |
| rd_data | output | DW | Result memory read data |

## Verification
Two events can fall in the same clock cycle: the rising edge of a new write strobe being registered, and the end of the run's last slot releasing busy_n. The bench provokes this by placing the strobe's falling edge in the second-to-last busy cycle and its rising edge in the last one. It then judges the result by checking that busy_n rises after exactly 18·N cycles, that it stays high afterwards, and that no extra samp pulse was counted. Stray strobes in the middle of a run are judged the same way.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int CH = 8,
  parameter int DW = 8,
  parameter int SLOT = 18,
  localparam int AW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          cfg_inhibit,
  input  logic          cfg_pdown,
  input  logic          cfg_single,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CH-1:0] chan_mask,
  input  logic          cmp_in,
  output logic          samp,
  output logic          busy_n,
  output logic [AW-1:0] conv_chan,
  output logic [DW-1:0] trial_code,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int SW = $clog2(SLOT);
  localparam int T0 = 2;
  localparam int ST = T0 + DW;

  logic          wr_q;
  logic [CH-1:0] pend, list, rest;
  logic [SW-1:0] slot, tidx;
  logic [DW-1:0] acc, bitmask;
  logic [DW-1:0] mem [CH];
  logic          in_trial, rise, fall, start;

  assign rise  = wr_n & ~wr_q & ~cs_n;
  assign fall  = ~wr_n & wr_q & ~cs_n;
  assign list  = cfg_single ? (CH'(1) << cfg_addr) : chan_mask;
  assign start = rise & busy_n & ~cfg_inhibit & ~cfg_pdown & (|list);

  always_comb begin
    conv_chan = '0;
    for (int i = CH - 1; i >= 0; i--)
      if (pend[i]) conv_chan = AW'(i);
  end

  assign rest       = pend & ~(CH'(1) << conv_chan);
  assign in_trial   = (slot >= SW'(T0)) && (slot < SW'(ST));
  assign tidx       = slot - SW'(T0);
  assign bitmask    = in_trial ? (DW'(1) << (SW'(DW - 1) - tidx)) : '0;
  assign trial_code = acc | bitmask;
  assign rd_data    = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      samp   <= 1'b0;
      busy_n <= 1'b1;
      pend   <= '0;
      slot   <= '0;
      acc    <= '0;
      for (int i = 0; i < CH; i++) mem[i] <= '0;
    end else begin
      wr_q <= wr_n;
      samp <= fall & busy_n;
      if (start) begin
        busy_n <= 1'b0;
        pend   <= list;
        slot   <= '0;
        acc    <= '0;
      end else if (!busy_n) begin
        if (in_trial && cmp_in) acc <= trial_code;
        if (slot == SW'(ST)) mem[conv_chan] <= acc;
        if (slot == SW'(SLOT - 1)) begin
          slot <= '0;
          acc  <= '0;
          pend <= rest;
          if (rest == '0) busy_n <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int CH = 8,
  parameter int SLOT = 18,
  localparam int AW = $clog2(CH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          cfg_inhibit,
  input logic          cfg_pdown,
  input logic          samp,
  input logic          busy_n,
  input logic [AW-1:0] conv_chan
);
  logic [15:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowcnt <= '0;
    else if (!busy_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;

  assert_start_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(wr_n) && !$past(wr_n, 2) && !$past(cs_n)
                       && !$past(cfg_inhibit) && !$past(cfg_pdown)));

  assert_samp_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> (!$past(wr_n) && $past(wr_n, 2) && !$past(cs_n)));

  assert_samp_not_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> $past(busy_n));

  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (lowcnt != 0 && (int'(lowcnt) % SLOT) == 0));

  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && !$past(busy_n)) |-> (conv_chan >= $past(conv_chan)));
endmodule

bind conv_sequencer conv_sequencer_chk #(.CH(CH), .SLOT(SLOT)) u_chk (.*);

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, cfg_inhibit = 1'b0, cfg_pdown = 1'b0, cfg_single = 1'b0;
  logic [2:0] cfg_addr = '0, rd_addr = '0, conv_chan;
  logic [7:0] chan_mask = '0, trial_code, rd_data;
  logic cmp_in, samp, busy_n;
  logic [7:0] vin [8];
  logic [7:0] exp_mem [8];
  logic [2:0] seq [16];
  int seqn = 0, samp_cnt = 0, errors = 0, checks = 0;

  always #5 clk = ~clk;

  assign cmp_in = (trial_code <= vin[conv_chan]);

  conv_sequencer i_conv_sequencer (.*);

  always @(negedge clk) begin
    if (samp) samp_cnt++;
    if (!busy_n && (seqn == 0 || seq[seqn-1] != conv_chan) && seqn < 16) begin
      seq[seqn] = conv_chan;
      seqn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      #1;
      chk(rd_data == exp_mem[i], req, rd_data, exp_mem[i]);
    end
  endtask

  task automatic run(input logic [7:0] mask, input logic single, input logic [2:0] addr,
                     input logic inh, input logic pd, input logic csn, input int poke,
                     input string req);
    logic [7:0] lst;
    int n, c, s0, k;
    bit go;
    lst = single ? (8'd1 << addr) : mask;
    n = $countones(lst);
    go = !csn && !inh && !pd && n > 0;
    @(negedge clk);
    chan_mask = mask; cfg_single = single; cfg_addr = addr;
    cfg_inhibit = inh; cfg_pdown = pd; cs_n = csn;
    seqn = 0; s0 = samp_cnt;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    chk(busy_n == !go, req, busy_n, !go);
    if (go) begin
      c = 1;
      while (c < 400) begin
        @(negedge clk);
        if (busy_n) break;
        c++;
        if (poke > 0 && c == poke) wr_n = 1'b0;
        if (poke > 0 && c == poke + 1) wr_n = 1'b1;
      end
      wr_n = 1'b1;
      chk(c == 18 * n, "R4 run length", c, 18 * n);
      chk(seqn == n, "R5 channel count", seqn, n);
      k = 0;
      for (int i = 0; i < 8; i++)
        if (lst[i]) begin
          if (k < seqn) chk(seq[k] == 3'(i), "R5 ascending order", seq[k], i);
          exp_mem[i] = vin[i];
          k++;
        end
    end
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1, "R11 no restart", busy_n, 1);
    chk(samp_cnt - s0 == (csn ? 0 : 1), csn ? "R10 samp" : "R2 samp count", samp_cnt - s0, csn ? 0 : 1);
    check_mem(req);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] masks [6];
    masks = '{8'hFF, 8'h01, 8'h80, 8'hA5, 8'h5A, 8'h3C};
    for (int i = 0; i < 8; i++) begin
      vin[i] = '0;
      exp_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1, "R1 busy reset", busy_n, 1);
    chk(samp == 1'b0, "R1 samp reset", samp, 0);
    rst_n = 1'b1;
    check_mem("R1 memory reset");

    for (int m = 0; m < 6; m++) begin
      for (int i = 0; i < 8; i++) vin[i] = 8'((m * 37 + i * 53 + 11) & 255);
      if (m == 0) begin vin[0] = 8'd0; vin[7] = 8'd255; end
      run(masks[m], 1'b0, 3'd0, 1'b0, 1'b0, 1'b0,
          (m == 3) ? 25 : ((m == 4) ? 18 * $countones(masks[m]) - 1 : 0), "R6 multi result");
    end

    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 8; i++) vin[i] = ~8'(v);
      vin[v % 8] = 8'(v);
      run(8'h00, 1'b1, 3'(v % 8), 1'b0, 1'b0, 1'b0, (v == 100) ? 17 : 0, "R7 single result");
    end

    for (int i = 0; i < 8; i++) vin[i] = 8'(i * 29 + 3);
    run(8'hFF, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 0, "R8 inhibit memory");
    run(8'hFF, 1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 0, "R9 powerdown memory");
    run(8'hFF, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 0, "R10 deselected memory");
    run(8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 0, "R12 empty list memory");
    run(8'h81, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 20, "R3 restart after idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule